// File: doc/BRIEF.md
# Hex Counter with Zero-Indicator Seven-Segment Display

This block holds a binary up-counter and presents its value on one or more seven-segment digits, four bits of count per digit. Each group of four bits is turned into a hexadecimal glyph covering 0 to 9 and A to F. Whenever the entire count is zero, every digit shows the letter E in place of the numeric glyphs. This marks the idle or just-cleared state at a glance.

The count advances by one on each clock edge where the enable is high, and a synchronous clear returns it to zero. Segment outputs are registered so that they leave the block glitch-free. A parameter chooses whether a lit segment is driven high (common-cathode wiring) or low (common-anode wiring). The decimal point of each digit is never lit. Digit multiplexing, switch debouncing and pin mapping live outside this block.

Top module: `hexdisp_top`

## Requirements
- R1: While rst_n is low and on the first cycle after it rises, the count is zero and every digit shows the E pattern.
- R2: On a clock edge with en high and clr low, the count rises by one. With en low and clr low, the count and display hold.
- R3: From all ones, an enabled edge wraps the count to zero, and the display then shows E.
- R4: Digit d shows bits [4d+3:4d] of the count. Its 7-bit field in seg_o is [7d+6:7d], with bit 0 = segment A (top), bits 1 to 5 = B to F (clockwise) and bit 6 = G (middle). The active-high glyphs, hex values 0 to F, are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71.
- R5: When the full count is zero, every digit field shows the letter E, which lights segments A, D, E, F and G (active-high 79), whatever the nibble decode would give.
- R6: seg_o reflects the count held one clock earlier, so a change in the count appears on the display one edge later.
- R7: With ACTIVE_LOW set, every segment and decimal-point bit is the inverse of its active-high value.
- R8: Every dp_o bit is always at the inactive level: 0 for active-high, 1 for active-low.
- R9: A clock edge with clr high sets the count to zero even when en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| clr | input | 1 | Synchronous clear of the count, takes priority over en |
| en | input | 1 | Count enable |
| seg_o | output | 7*DIGITS | Registered segment fields, 7 bits per digit, digit 0 lowest |
| dp_o | output | DIGITS | Decimal point per digit, always inactive |

## Verification
On every cycle, the assertions check the counter's increment, hold, clear priority and wrap, and that a zero count is followed by all-E segments and idle decimal points. Only the bench's scenarios can show the full glyph table, the one-clock lag between count and display, and the inverted outputs of the active-low build. The bench gets these by comparing against a behavioural model across random enable patterns, a full run through every count value, and clear-while-enabled sequences.

// File: rtl/hexdisp_pkg.sv
package hexdisp_pkg;
  typedef logic [6:0] seg7_t;
  // segment bit order: 0=A top, 1..5=B..F clockwise, 6=G middle
  localparam seg7_t SEG_LETTER_E = 7'h79;
  localparam int    NIBBLE_W     = 4;
  localparam int    SEG_W        = 7;
endpackage

// File: rtl/hexdisp_counter.sv
module hexdisp_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [WIDTH-1:0] count_q
);
  logic [WIDTH-1:0] count_d;

  always_comb begin
    count_d = count_q;
    if (clr) begin
      count_d = '0;
    end else if (en) begin
      count_d = count_q + {{(WIDTH-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else begin
      count_q <= count_d;
    end
  end
endmodule

// File: rtl/hexdisp_nibble_dec.sv
module hexdisp_nibble_dec
  import hexdisp_pkg::*;
(
  input  logic [NIBBLE_W-1:0] nib,
  output seg7_t               seg
);
  always_comb begin
    unique case (nib)
      4'h0: seg = 7'h3F;
      4'h1: seg = 7'h06;
      4'h2: seg = 7'h5B;
      4'h3: seg = 7'h4F;
      4'h4: seg = 7'h66;
      4'h5: seg = 7'h6D;
      4'h6: seg = 7'h7D;
      4'h7: seg = 7'h07;
      4'h8: seg = 7'h7F;
      4'h9: seg = 7'h6F;
      4'hA: seg = 7'h77;
      4'hB: seg = 7'h7C;
      4'hC: seg = 7'h39;
      4'hD: seg = 7'h5E;
      4'hE: seg = 7'h79;
      default: seg = 7'h71;
    endcase
  end
endmodule

// File: rtl/hexdisp_seg_reg.sv
module hexdisp_seg_reg
  import hexdisp_pkg::*;
#(
  parameter int DIGITS     = 2,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  is_zero,
  input  logic [SEG_W*DIGITS-1:0] dec_flat,
  output logic [SEG_W*DIGITS-1:0] seg_o,
  output logic [DIGITS-1:0]     dp_o
);
  localparam seg7_t POL_MASK = {SEG_W{ACTIVE_LOW}};

  logic [SEG_W*DIGITS-1:0] seg_d;

  for (genvar d = 0; d < DIGITS; d++) begin : g_sel
    seg7_t shown;
    always_comb begin
      shown = is_zero ? SEG_LETTER_E : dec_flat[SEG_W*d +: SEG_W];
      seg_d[SEG_W*d +: SEG_W] = shown ^ POL_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_o <= {DIGITS{SEG_LETTER_E ^ POL_MASK}};
    end else begin
      seg_o <= seg_d;
    end
  end

  assign dp_o = {DIGITS{ACTIVE_LOW}};
endmodule

// File: rtl/hexdisp_top.sv
module hexdisp_top
  import hexdisp_pkg::*;
#(
  parameter int DIGITS     = 2,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  output logic [SEG_W*DIGITS-1:0] seg_o,
  output logic [DIGITS-1:0]       dp_o
);
  localparam int CNT_W = NIBBLE_W * DIGITS;

  logic [CNT_W-1:0]        count_q;
  logic [SEG_W*DIGITS-1:0] dec_flat;
  logic                    is_zero;

  hexdisp_counter #(.WIDTH(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .en      (en),
    .count_q (count_q)
  );

  for (genvar d = 0; d < DIGITS; d++) begin : g_dec
    hexdisp_nibble_dec u_dec (
      .nib (count_q[NIBBLE_W*d +: NIBBLE_W]),
      .seg (dec_flat[SEG_W*d +: SEG_W])
    );
  end

  assign is_zero = (count_q == '0);

  hexdisp_seg_reg #(.DIGITS(DIGITS), .ACTIVE_LOW(ACTIVE_LOW)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .is_zero  (is_zero),
    .dec_flat (dec_flat),
    .seg_o    (seg_o),
    .dp_o     (dp_o)
  );
endmodule

// File: rtl/hexdisp_checker.sv
module hexdisp_checker
  import hexdisp_pkg::*;
#(
  parameter int DIGITS     = 2,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           clr,
  input logic                           en,
  input logic [NIBBLE_W*DIGITS-1:0]     cnt,
  input logic [SEG_W*DIGITS-1:0]        seg_o,
  input logic [DIGITS-1:0]              dp_o
);
  localparam int CNT_W = NIBBLE_W * DIGITS;
  localparam logic [SEG_W*DIGITS-1:0] ALL_E =
    {DIGITS{SEG_LETTER_E ^ {SEG_W{ACTIVE_LOW}}}};

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(cnt));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && (cnt == {CNT_W{1'b1}})) |=> (cnt == '0));

  p_zero_shows_e_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |=> (seg_o == ALL_E));

  p_dp_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dp_o == {DIGITS{ACTIVE_LOW}});

  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

bind hexdisp_top hexdisp_checker #(.DIGITS(DIGITS), .ACTIVE_LOW(ACTIVE_LOW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .clr   (clr),
  .en    (en),
  .cnt   (count_q),
  .seg_o (seg_o),
  .dp_o  (dp_o)
);

// File: tb/hexdisp_top_tb.sv
`timescale 1ns/1ps
module hexdisp_top_tb;
  localparam int DIGITS = 2;
  localparam int CNT_W  = 4 * DIGITS;
  localparam int MODULO = 1 << CNT_W;
  localparam int SW     = 7 * DIGITS;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, clr, en;
  logic [SW-1:0]     seg_hi, seg_lo;
  logic [DIGITS-1:0] dp_hi, dp_lo;

  hexdisp_top #(.DIGITS(DIGITS), .ACTIVE_LOW(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .seg_o(seg_hi), .dp_o(dp_hi));
  hexdisp_top #(.DIGITS(DIGITS), .ACTIVE_LOW(1'b1)) u_dut_al (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .seg_o(seg_lo), .dp_o(dp_lo));

  int    checks = 0;
  int    fails  = 0;
  string tag    = "R1";
  bit    done   = 1'b0;

  logic [6:0] glyph [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                             7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};

  function automatic logic [SW-1:0] show(int value);
    logic [SW-1:0] r;
    for (int d = 0; d < DIGITS; d++) begin
      if (value == 0) r[7*d +: 7] = 7'h79;
      else            r[7*d +: 7] = glyph[(value >> (4*d)) & 15];
    end
    return r;
  endfunction

  // reference model: count plus display lagging by one edge
  int            m_cnt;
  logic [SW-1:0] m_seg;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0;
      m_seg = show(0);
    end else begin
      m_seg = show(m_cnt);
      if (clr)     m_cnt = 0;
      else if (en) m_cnt = (m_cnt + 1) % MODULO;
    end
  end

  task automatic check(string req, logic [SW-1:0] act, logic [SW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(tag, seg_hi, m_seg);
      check("R7", seg_lo, ~m_seg);
      check("R8", SW'(dp_hi), SW'({DIGITS{1'b0}}));
      check("R8", SW'(dp_lo), SW'({DIGITS{1'b1}}));
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int lfsr;
    rst_n = 1'b0; clr = 1'b0; en = 1'b0;
    tag = "R1";
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    // one enabled edge: display still E next sample, digit 1 after that
    tag = "R6";
    en = 1'b1; cycles(1);
    en = 1'b0; cycles(2);
    // random enable pattern, including holds
    tag = "R2";
    lfsr = 32'h1D;
    for (int i = 0; i < 60; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB8 : 0);
      en = lfsr[0];
      cycles(1);
    end
    en = 1'b0; cycles(2);
    // clear while enabled
    tag = "R9";
    en = 1'b1; clr = 1'b1; cycles(2);
    clr = 1'b0; en = 1'b0; cycles(2);
    // every glyph value in sequence
    tag = "R4";
    en = 1'b1; cycles(MODULO - 4);
    // wrap past all ones
    tag = "R3";
    cycles(8);
    en = 1'b0;
    tag = "R5";
    clr = 1'b1; cycles(1);
    clr = 1'b0; cycles(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule